// File: doc/BRIEF.md
# Asynchronous Serial Byte Receiver

The block recovers bytes from a single asynchronous serial line that idles high. Each frame has one low start bit, eight data bits with the least significant bit first, and one high stop bit. There is no parity bit. The length of one bit is given at run time, in system clock cycles, by a 16-bit input. That lets one build of the block serve several line rates.

The raw line first passes through a two-flop synchronizer. A falling edge arms the receiver. The start bit is confirmed half a bit later, and every later bit is sampled one full bit period after the one before it, so each sample lands near the middle of its bit. A good frame ends with a one-cycle valid strobe, and the byte stays on the data output until the next good frame replaces it. A frame whose stop bit reads low is dropped. The receiver then waits for the line to go high before it can arm again.

Top module: `serial_byte_rx`

## Requirements
- R1: While idle, a low level on the line (seen after the two-flop synchronizer) starts a frame. A line that stays high never produces a byte.
- R2: The start bit is sampled again half a bit period after the falling edge. If the line is high at that point, the event is dropped with no valid strobe, and a good frame that follows is received normally.
- R3: The first data bit received lands in output bit 0 and the last in bit 7. For example, a byte transmitted as 0x01 is reported as 0x01, not 0x80.
- R4: valid_o rises only after the stop bit has been sampled high. It is high for exactly one clock cycle per good frame, and data_o carries the received byte in that cycle.
- R5: data_o changes only in a cycle where valid_o is high, and otherwise holds the last good byte.
- R6: One bit lasts cpb_i clock cycles, and cpb_i is read at run time. Bytes are received correctly at several different values of cpb_i, from 6 upward.
- R7: Frames that follow one another with no idle time between the stop bit and the next start bit are all received, in order and with no limit on their number.
- R8: If the stop bit samples low, no valid strobe is issued. While the line then stays low no new frame starts, and after the line returns high the next good frame is received.
- R9: While rst_ni is low, valid_o is 0 and data_o is 0x00. A frame cut short by reset produces no byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpb_i | input | 16 | Clock cycles per bit (6 or more) |
| rx_i | input | 1 | Raw serial line, idles high |
| valid_o | output | 1 | One-cycle strobe when a good byte is available |
| data_o | output | 8 | Last good byte received |

## Verification
The bench uses bytes that tell bit order apart, such as 0x01 against 0x80. A receiver that shifts the wrong way reports them mirrored. It drives a short low pulse on an idle line: a receiver without the half-bit recheck would decode that pulse as a 0x00 or 0xFF byte. It sends a frame with a low stop bit and then holds the line low for several bit times, so that a receiver which re-arms at once would report a spurious 0x00 when the line rises. Back-to-back frames at several runtime bit periods, and a reset in the middle of a frame, show up any off-by-one in the bit timer and any state that survives reset.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned CNT_W  = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP,
    ST_WAIT_HIGH
  } rx_state_e;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) pipe_q[0] <= 1'b1;
          else         pipe_q[0] <= d_i;
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) pipe_q[i] <= 1'b1;
          else         pipe_q[i] <= pipe_q[i-1];
      end
    end
  endgenerate

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/rx_bit_timer.sv
module rx_bit_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] cpb_i,
  output logic             half_o,
  output logic             full_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] half_w, half_m1, full_m1;

  assign half_w  = cpb_i >> 1;
  assign half_m1 = (half_w == '0) ? '0 : half_w - 1'b1;
  assign full_m1 = (cpb_i  == '0) ? '0 : cpb_i  - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;

  assign half_o = (cnt_q == half_m1);
  assign full_o = (cnt_q == full_m1);

  // counter restarts from zero after a clear
  AST_TIMER_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0); // R6
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import serial_rx_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          line_i,
  input  logic          half_i,
  input  logic          full_i,
  output logic          clr_o,
  output logic          valid_o,
  output logic [DW-1:0] data_o
);
  localparam int unsigned IDX_W = $clog2(DW);

  rx_state_e        state_q, state_d;
  logic [IDX_W-1:0] idx_q;
  logic [DW-1:0]    shr_q;
  logic             good_stop;

  always_comb begin
    state_d = state_q;
    clr_o   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        clr_o = 1'b1;
        if (!line_i) state_d = ST_START;
      end
      ST_START:
        if (half_i) begin
          clr_o   = 1'b1;
          state_d = line_i ? ST_IDLE : ST_DATA; // high again: glitch
        end
      ST_DATA:
        if (full_i) begin
          clr_o = 1'b1;
          if (idx_q == IDX_W'(DW-1)) state_d = ST_STOP;
        end
      ST_STOP:
        if (full_i) begin
          clr_o   = 1'b1;
          state_d = line_i ? ST_IDLE : ST_WAIT_HIGH;
        end
      ST_WAIT_HIGH: begin
        clr_o = 1'b1;
        if (line_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign good_stop = (state_q == ST_STOP) && full_i && line_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      shr_q   <= '0;
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      state_q <= state_d;
      valid_o <= good_stop;
      if (good_stop) data_o <= shr_q;
      if (state_q == ST_START) idx_q <= '0;
      if (state_q == ST_DATA && full_i) begin
        shr_q <= {line_i, shr_q[DW-1:1]}; // LSB first
        idx_q <= idx_q + 1'b1;
      end
    end

  AST_IDLE_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !line_i) |=> state_q == ST_START); // R1
  AST_GLITCH_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_START && half_i && line_i) |=> (state_q == ST_IDLE && !valid_o)); // R2
  AST_VALID_AFTER_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(state_q) == ST_STOP); // R4
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R4
  AST_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(data_o) |-> valid_o); // R5
  AST_BAD_STOP_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STOP && full_i && !line_i) |=> (!valid_o && state_q == ST_WAIT_HIGH)); // R8
  AST_WAIT_NO_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT_HIGH && !line_i) |=> state_q == ST_WAIT_HIGH); // R8
endmodule

// File: rtl/serial_byte_rx.sv
module serial_byte_rx
  import serial_rx_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  cpb_i,
  input  logic              rx_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);
  logic line_s, clr_w, half_w, full_w;

  rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rx_i),
    .q_o   (line_s)
  );

  rx_bit_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr_w),
    .cpb_i (cpb_i),
    .half_o(half_w),
    .full_o(full_w)
  );

  rx_frame_fsm #(.DW(DATA_W)) u_fsm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .line_i (line_s),
    .half_i (half_w),
    .full_i (full_w),
    .clr_o  (clr_w),
    .valid_o(valid_o),
    .data_o (data_o)
  );

  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |-> (!valid_o && data_o == '0)); // R9
endmodule

// File: tb/serial_byte_rx_tb.sv
`timescale 1ns/1ps
module serial_byte_rx_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpb = 16'd16;
  logic        rx = 1'b1;
  logic        valid;
  logic [7:0]  data;

  int n_chk = 0, n_fail = 0, n_valid = 0;
  logic [7:0] exp_q[$];
  logic [7:0] prev_data = 8'h00;
  logic       prev_valid = 1'b0;
  string      cur_req = "R4";

  always #10 clk = ~clk;

  serial_byte_rx dut_i (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .cpb_i  (cpb),
    .rx_i   (rx),
    .valid_o(valid),
    .data_o (data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // monitor on the falling edge, away from design updates
  always @(negedge clk) begin
    if (rst_n) begin
      if (valid) begin
        n_valid++;
        chk(!prev_valid, "R4 single-cycle valid", 1, 0);
        if (exp_q.size() == 0) chk(1'b0, {cur_req, " unexpected byte"}, data, 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(data == e, cur_req, data, e);
        end
      end else if (data != prev_data) begin
        chk(1'b0, "R5 data changed without valid", data, prev_data);
      end
      prev_valid = valid;
      prev_data  = data;
    end else begin
      prev_valid = 1'b0;
      prev_data  = 8'h00;
    end
  end

  task automatic hold(input logic lvl, input int cyc);
    rx = lvl;
    repeat (cyc) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b, input int c, input logic stop_lvl, input bit expect_it);
    cpb = 16'(c);
    if (expect_it) exp_q.push_back(b);
    hold(1'b0, c);
    for (int i = 0; i < 8; i++) hold(b[i], c);
    hold(stop_lvl, c);
    if (stop_lvl) rx = 1'b1;
  endtask

  task automatic settle(input int cyc);
    rx = 1'b1;
    repeat (cyc) @(negedge clk);
  endtask

  initial begin
    int wd = 0;
    while (wd < 150000) begin @(posedge clk); wd++; end
    chk(1'b0, "watchdog", wd, 0);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(valid == 1'b0, "R9 reset valid", valid, 0);
    chk(data == 8'h00, "R9 reset data", data, 0);
    rst_n = 1'b1;
    settle(100);
    chk(n_valid == 0, "R1 idle-high line yields nothing", n_valid, 0);

    // bit order
    cur_req = "R3 LSB first";
    send(8'h01, 16, 1'b1, 1); settle(40);
    send(8'h80, 16, 1'b1, 1); settle(40);
    send(8'hD5, 16, 1'b1, 1); settle(40);
    chk(n_valid == 3 && data == 8'hD5, "R3 count/last", data, 8'hD5);

    // glitch on idle line
    cur_req = "R2 glitch";
    cpb = 16'd16;
    hold(1'b0, 4); settle(80);
    chk(n_valid == 3, "R2 glitch dropped", n_valid, 3);
    chk(data == 8'hD5, "R2 data held", data, 8'hD5);
    send(8'h3C, 16, 1'b1, 1); settle(40);
    chk(n_valid == 4, "R2 frame after glitch", n_valid, 4);

    // back-to-back, no idle gap
    cur_req = "R7 back-to-back";
    send(8'h00, 12, 1'b1, 1);
    send(8'hFF, 12, 1'b1, 1);
    send(8'h30, 12, 1'b1, 1);
    send(8'hA5, 12, 1'b1, 1);
    settle(40);
    chk(n_valid == 8, "R7 all back-to-back bytes", n_valid, 8);

    // bad stop, then line held low: must not re-arm
    cur_req = "R8 bad stop";
    send(8'h5A, 16, 1'b0, 0);
    hold(1'b0, 64);
    settle(200);
    chk(n_valid == 8, "R8 no byte from bad frame", n_valid, 8);
    chk(data == 8'hA5, "R8 data held", data, 8'hA5);
    send(8'h96, 16, 1'b1, 1); settle(40);
    chk(n_valid == 9 && data == 8'h96, "R8 recovery", data, 8'h96);

    // reset mid-frame
    cur_req = "R9 reset";
    cpb = 16'd16;
    hold(1'b0, 16); hold(1'b1, 16); hold(1'b0, 20);
    rst_n = 1'b0; rx = 1'b1;
    @(negedge clk);
    chk(valid == 1'b0 && data == 8'h00, "R9 mid-frame reset", data, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle(200);
    chk(n_valid == 9, "R9 truncated frame dropped", n_valid, 9);
    send(8'h42, 16, 1'b1, 1); settle(40);
    chk(data == 8'h42, "R9 receive after reset", data, 8'h42);

    // random bytes at random runtime bit periods
    cur_req = "R6 random cpb";
    for (int k = 0; k < 40; k++) begin
      int c, g;
      logic [7:0] b;
      c = 6 + int'($urandom % 35);
      g = int'($urandom % 4);
      b = 8'($urandom);
      send(b, c, 1'b1, 1);
      settle(g * c);
    end
    settle(120);
    chk(n_valid == 50, "R6 random byte count", n_valid, 50);
    chk(exp_q.size() == 0, "R6 no missing bytes", exp_q.size(), 0);

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule